// File: doc/BRIEF.md
# Mixed-Radix Digit-Reversed Position Generator

This block sits beside the output of a streaming mixed-radix transform whose results leave the pipeline in digit-reversed order. For every valid output sample it emits the natural-order index of that sample. A consumer that writes each sample to that address finds the frame in natural order. The transform length is chosen per frame from a small table of sizes built only from the factors 2, 3 and 5. Frames may follow one another with no idle cycle, and the length may change at each frame.

Internally a mixed-radix digit counter advances once per valid sample, with carries running from the fastest stage upward. The position is kept in a register that is corrected by one precomputed weight step per sample, so no multiplier sits on the per-cycle path. The per-size stage lists, weights and wrap corrections are constants computed at elaboration. The register that holds them is loaded when a frame starts.

Top module: `mrp_pos_gen`

## Requirements
- R1: While reset is held and after it, before any valid sample, `out_valid`, `out_start` and `out_last` are low and `out_size_idx` is 0.
- R2: A sample with `in_valid` and `in_start` both high is emitted with `out_pos` = 0 and `out_start` high, and `out_size_idx` shows the index given with it.
- R3: For sample k (counting from 0) of a frame with stage radices r0..r(S-1), stage 0 first, write k = c0 + r0·(c1 + r1·(c2 + ...)) with 0 ≤ ci < ri. The emitted position is the sum of ci·(r(i+1)·...·r(S-1)).
- R4: Size indices 0..7 select lengths 12, 24, 36, 48, 60, 72, 96 and 120. A length's stage list places every radix-5 stage first, then the radix-3 stages, then the radix-2 stages. The size index is sampled only on a valid start sample.
- R5: The positions of a complete frame of length N are a permutation of 0..N−1.
- R6: A cycle with `in_valid` low gives `out_valid` low one cycle later. `in_start` and `in_size_idx` are ignored in such a cycle, and the count holds, so the next valid sample continues the frame.
- R7: `out_last` is high exactly with the N-th sample of a frame, whose position is N−1.
- R8: Frames of different lengths may follow each other on consecutive cycles with no gap.
- R9: Valid samples beyond N without a new start wrap to position 0 and count a new frame of the same length.
- R10: After reset, a first valid sample without a start gets position 0 of a length-12 frame (index 0), and later samples continue it.
- R11: Each valid input sample produces its output exactly one clock later.
- R12: A start in the middle of a frame abandons it and begins a new frame at position 0 with the newly given size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A transform output sample is present this cycle |
| in_start | input | 1 | First sample of a frame; qualified by in_valid |
| in_size_idx | input | 3 | Size index, used only with a valid start |
| out_valid | output | 1 | out_pos is valid |
| out_start | output | 1 | out_pos belongs to the first sample of a frame |
| out_last | output | 1 | out_pos belongs to the final sample of a frame |
| out_size_idx | output | 3 | Size index of the frame being numbered |
| out_pos | output | 7 | Natural-order index of the current sample |

## Verification
A corrupted digit or a stale weight shows up at `out_pos` on the very next valid sample, as a position that differs from the arithmetic digit reversal. A position that falls out of range, or a duplicate inside the frame, is flagged at the same time. A lost or extra carry breaks the permutation property and moves `out_last` away from position N−1 within one frame. A stale size after a start is visible from the second sample of the new frame. Every length is swept exhaustively, with continuous and gapped valid patterns, overrun and mid-frame restarts.

// File: rtl/mrp_pkg.sv
// Package: shared constants and elaboration-time helpers for the mixed-radix
// position generator. Assumes every table length factors into 2, 3 and 5
// and needs no more than MRP_MAX_STAGES stages.
package mrp_pkg;

    localparam int MRP_NUM_SIZES  = 8;
    localparam int MRP_MAX_STAGES = 6;
    localparam int MRP_MAX_N      = 120;
    localparam int MRP_DIG_W      = 3;

    // Frame length for each size index.
    function automatic int unsigned mrp_size(input int unsigned idx);
        case (idx)
            0:       return 12;
            1:       return 24;
            2:       return 36;
            3:       return 48;
            4:       return 60;
            5:       return 72;
            6:       return 96;
            7:       return 120;
            default: return 12;
        endcase
    endfunction

    // Multiplicity of factor r in n.
    function automatic int unsigned mrp_count(input int unsigned n, input int unsigned r);
        int unsigned m;
        int unsigned c;
        m = n;
        c = 0;
        for (int i = 0; i < 16; i++) begin
            if (m != 0 && (m % r) == 0) begin
                m = m / r;
                c = c + 1;
            end
        end
        return c;
    endfunction

    // Radix of a stage: fives first, then threes, then twos, unused = 1.
    function automatic int unsigned mrp_radix(input int unsigned idx, input int unsigned stage);
        int unsigned n;
        int unsigned f;
        int unsigned t;
        int unsigned w;
        n = mrp_size(idx);
        f = mrp_count(n, 5);
        t = mrp_count(n, 3);
        w = mrp_count(n, 2);
        if (stage < f)              return 5;
        else if (stage < f + t)     return 3;
        else if (stage < f + t + w) return 2;
        else                        return 1;
    endfunction

    // Weight of a stage digit: product of all later stage radices.
    function automatic int unsigned mrp_weight(input int unsigned idx, input int unsigned stage);
        int unsigned p;
        p = 1;
        for (int j = 0; j < MRP_MAX_STAGES; j++) begin
            if (j > int'(stage)) p = p * mrp_radix(idx, j);
        end
        return p;
    endfunction

endpackage

// File: rtl/mrp_plan_rom.sv
// Module: constant plan table. For a size index it returns, per stage, the
// largest digit value, the digit weight and the wrap correction, plus the
// last position N-1. All entries are elaboration-time constants; the lookup
// is a plain multiplexer. Assumes size_idx < NUM_SIZES.
module mrp_plan_rom
    import mrp_pkg::*;
#(
    parameter int NUM_SIZES  = MRP_NUM_SIZES,
    parameter int MAX_STAGES = MRP_MAX_STAGES,
    parameter int DIG_W      = MRP_DIG_W,
    parameter int POS_W      = $clog2(MRP_MAX_N),
    localparam int IDX_W     = $clog2(NUM_SIZES)
) (
    input  logic [IDX_W-1:0]                  size_idx,
    output logic [MAX_STAGES-1:0][DIG_W-1:0]  rm1,
    output logic [MAX_STAGES-1:0][POS_W-1:0]  weight,
    output logic [MAX_STAGES-1:0][POS_W-1:0]  back,
    output logic [POS_W-1:0]                  last_pos
);

    typedef logic [MAX_STAGES-1:0][DIG_W-1:0] dig_row_t;
    typedef logic [MAX_STAGES-1:0][POS_W-1:0] pos_row_t;

    function automatic dig_row_t rm1_row(input int unsigned s);
        dig_row_t r;
        for (int g = 0; g < MAX_STAGES; g++) r[g] = DIG_W'(mrp_radix(s, g) - 1);
        return r;
    endfunction

    function automatic pos_row_t weight_row(input int unsigned s);
        pos_row_t r;
        for (int g = 0; g < MAX_STAGES; g++) r[g] = POS_W'(mrp_weight(s, g));
        return r;
    endfunction

    function automatic pos_row_t back_row(input int unsigned s);
        pos_row_t r;
        for (int g = 0; g < MAX_STAGES; g++)
            r[g] = POS_W'((mrp_radix(s, g) - 1) * mrp_weight(s, g));
        return r;
    endfunction

    dig_row_t           rm1_tab    [NUM_SIZES];
    pos_row_t           weight_tab [NUM_SIZES];
    pos_row_t           back_tab   [NUM_SIZES];
    logic [POS_W-1:0]   last_tab   [NUM_SIZES];

    // One constant row per supported size.
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        assign rm1_tab[s]    = rm1_row(s);
        assign weight_tab[s] = weight_row(s);
        assign back_tab[s]   = back_row(s);
        assign last_tab[s]   = POS_W'(mrp_size(s) - 1);
    end

    // Select the row of the requested size.
    always_comb begin
        rm1      = rm1_tab[size_idx];
        weight   = weight_tab[size_idx];
        back     = back_tab[size_idx];
        last_pos = last_tab[size_idx];
    end

endmodule

// File: rtl/mrp_digit_counter.sv
// Module: mixed-radix digit counter in emission order. Digit 0 is the
// fastest; a digit at its maximum wraps to 0 and carries upward. Reports per
// stage whether a carry reaches it and whether it wraps. Assumes rm1 holds
// the current frame's digit maxima; reset leaves the count at the final
// pattern of a size-index-0 frame so the next step gives all zeros.
module mrp_digit_counter
    import mrp_pkg::*;
#(
    parameter int MAX_STAGES = MRP_MAX_STAGES,
    parameter int DIG_W      = MRP_DIG_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              restart,
    input  logic                              step,
    input  logic [MAX_STAGES-1:0][DIG_W-1:0]  rm1,
    output logic [MAX_STAGES-1:0]             carry_in,
    output logic [MAX_STAGES-1:0]             wrap,
    output logic                              all_max
);

    logic [MAX_STAGES-1:0][DIG_W-1:0] digit;

    // Per-stage wrap detection and carry propagation.
    for (genvar g = 0; g < MAX_STAGES; g++) begin : g_carry
        assign wrap[g] = (digit[g] == rm1[g]);
        if (g == 0) begin : g_first
            assign carry_in[g] = 1'b1;
        end else begin : g_rest
            assign carry_in[g] = &wrap[g-1:0];
        end
    end

    assign all_max = &wrap;

    // Digit registers: reset to final pattern, clear on start, step with carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < MAX_STAGES; g++) digit[g] <= DIG_W'(mrp_radix(0, g) - 1);
        end else if (restart) begin
            digit <= '0;
        end else if (step) begin
            for (int g = 0; g < MAX_STAGES; g++) begin
                if (carry_in[g]) digit[g] <= wrap[g] ? '0 : digit[g] + DIG_W'(1);
            end
        end
    end

    // Each digit stays below its stage radix (R3).
    for (genvar g = 0; g < MAX_STAGES; g++) begin : g_chk
        a_r3_digit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            digit[g] <= rm1[g]);
    end

endmodule

// File: rtl/mrp_pos_accum.sv
// Module: incremental position register. Each step adds the weight of the
// first non-wrapping digit and subtracts the correction of every wrapping
// digit below it, all modulo 2^POS_W. Assumes carry_in/wrap come from the
// digit counter for the same cycle; reset value matches the counter's reset.
module mrp_pos_accum
    import mrp_pkg::*;
#(
    parameter int MAX_STAGES = MRP_MAX_STAGES,
    parameter int POS_W      = $clog2(MRP_MAX_N)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              restart,
    input  logic                              step,
    input  logic [MAX_STAGES-1:0]             carry_in,
    input  logic [MAX_STAGES-1:0]             wrap,
    input  logic [MAX_STAGES-1:0][POS_W-1:0]  weight,
    input  logic [MAX_STAGES-1:0][POS_W-1:0]  back,
    output logic [POS_W-1:0]                  pos
);

    logic [POS_W-1:0] delta;

    // Net position change for one step of the digit counter.
    always_comb begin
        delta = '0;
        for (int g = 0; g < MAX_STAGES; g++) begin
            if (carry_in[g]) begin
                if (wrap[g]) delta = delta - back[g];
                else         delta = delta + weight[g];
            end
        end
    end

    // Position register: reset to N0-1, zero on start, accumulate on step.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= POS_W'(mrp_size(0) - 1);
        else if (restart) pos <= '0;
        else if (step)    pos <= pos + delta;
    end

endmodule

// File: rtl/mrp_pos_gen.sv
// Module: top of the mixed-radix reversed position generator. Latches the
// plan of the size named with a valid start, drives the digit counter and
// the position accumulator, and presents the position one cycle after each
// valid input. Assumes in_start is meaningful only with in_valid and that
// in_size_idx is a legal table index.
module mrp_pos_gen
    import mrp_pkg::*;
#(
    parameter int NUM_SIZES  = MRP_NUM_SIZES,
    parameter int MAX_STAGES = MRP_MAX_STAGES,
    parameter int DIG_W      = MRP_DIG_W,
    parameter int POS_W      = $clog2(MRP_MAX_N),
    localparam int IDX_W     = $clog2(NUM_SIZES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [IDX_W-1:0]  in_size_idx,
    output logic              out_valid,
    output logic              out_start,
    output logic              out_last,
    output logic [IDX_W-1:0]  out_size_idx,
    output logic [POS_W-1:0]  out_pos
);

    logic take_start;
    logic take_step;

    logic [MAX_STAGES-1:0][DIG_W-1:0] rom_rm1,    rst_rm1,    rm1_q;
    logic [MAX_STAGES-1:0][POS_W-1:0] rom_weight, rst_weight, weight_q;
    logic [MAX_STAGES-1:0][POS_W-1:0] rom_back,   rst_back,   back_q;
    logic [POS_W-1:0]                 rom_last,   rst_last,   last_q;
    logic [IDX_W-1:0]                 idx_q;

    logic [MAX_STAGES-1:0] carry_in;
    logic [MAX_STAGES-1:0] wrap;
    logic                  all_max;
    logic                  valid_q;
    logic                  start_q;

    assign take_start = in_valid & in_start;
    assign take_step  = in_valid & ~in_start;

    // Plan of the size requested with the current start.
    mrp_plan_rom #(
        .NUM_SIZES (NUM_SIZES),
        .MAX_STAGES(MAX_STAGES),
        .DIG_W     (DIG_W),
        .POS_W     (POS_W)
    ) u_rom (
        .size_idx(in_size_idx),
        .rm1     (rom_rm1),
        .weight  (rom_weight),
        .back    (rom_back),
        .last_pos(rom_last)
    );

    // Plan of size index 0, used as the reset value.
    mrp_plan_rom #(
        .NUM_SIZES (NUM_SIZES),
        .MAX_STAGES(MAX_STAGES),
        .DIG_W     (DIG_W),
        .POS_W     (POS_W)
    ) u_rom_rst (
        .size_idx('0),
        .rm1     (rst_rm1),
        .weight  (rst_weight),
        .back    (rst_back),
        .last_pos(rst_last)
    );

    // Frame plan register, loaded on a valid start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rm1_q    <= rst_rm1;
            weight_q <= rst_weight;
            back_q   <= rst_back;
            last_q   <= rst_last;
            idx_q    <= '0;
        end else if (take_start) begin
            rm1_q    <= rom_rm1;
            weight_q <= rom_weight;
            back_q   <= rom_back;
            last_q   <= rom_last;
            idx_q    <= in_size_idx;
        end
    end

    mrp_digit_counter #(
        .MAX_STAGES(MAX_STAGES),
        .DIG_W     (DIG_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (take_start),
        .step    (take_step),
        .rm1     (rm1_q),
        .carry_in(carry_in),
        .wrap    (wrap),
        .all_max (all_max)
    );

    mrp_pos_accum #(
        .MAX_STAGES(MAX_STAGES),
        .POS_W     (POS_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (take_start),
        .step    (take_step),
        .carry_in(carry_in),
        .wrap    (wrap),
        .weight  (weight_q),
        .back    (back_q),
        .pos     (out_pos)
    );

    // Output qualifiers, one cycle behind the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            start_q <= take_start;
        end
    end

    assign out_valid    = valid_q;
    assign out_start    = start_q;
    assign out_last     = valid_q & all_max;
    assign out_size_idx = idx_q;

    // A frame's first position is zero (R2).
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_start |-> out_pos == '0);

    // Positions stay inside the current frame (R5).
    a_r5_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pos <= last_q);

    // The final digit pattern maps to N-1 (R7).
    a_r7_last_is_max: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_pos == last_q);

    // An idle input cycle leaves the position untouched (R6).
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pos));

    // A sample right after the last one, without a start, is position 0 (R9).
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_start && $past(out_valid && out_last) |-> out_pos == '0);

endmodule

// File: tb/test_mrp_pos_gen.sv
`timescale 1ns/1ps
module test_mrp_pos_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [2:0] in_size_idx = '0;
    logic       out_valid;
    logic       out_start;
    logic       out_last;
    logic [2:0] out_size_idx;
    logic [6:0] out_pos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the frame being numbered.
    int    m_idx;
    int    m_k;
    bit    p_valid = 1'b0;
    bit    p_start;
    bit    p_last;
    int    p_pos;
    int    p_idx;
    int    p_k;
    string tag = "R3";
    bit    seen [128];
    int    distinct;

    always #2 clk = ~clk;

    mrp_pos_gen i_mrp_pos_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .in_size_idx (in_size_idx),
        .out_valid   (out_valid),
        .out_start   (out_start),
        .out_last    (out_last),
        .out_size_idx(out_size_idx),
        .out_pos     (out_pos)
    );

    function automatic int bsize(input int idx);
        case (idx)
            0: return 12;  1: return 24;  2: return 36;  3: return 48;
            4: return 60;  5: return 72;  6: return 96;  default: return 120;
        endcase
    endfunction

    // Arithmetic digit reversal from the requirement (R3, R4).
    function automatic int ref_pos(input int idx, input int k);
        int rads [8];
        int nr = 0;
        int m = bsize(idx);
        int kk = k;
        int pos = 0;
        while (m % 5 == 0) begin rads[nr] = 5; nr++; m = m / 5; end
        while (m % 3 == 0) begin rads[nr] = 3; nr++; m = m / 3; end
        while (m % 2 == 0) begin rads[nr] = 2; nr++; m = m / 2; end
        for (int i = 0; i < nr; i++) begin
            int d = kk % rads[i];
            int w = 1;
            kk = kk / rads[i];
            for (int j = i + 1; j < nr; j++) w = w * rads[j];
            pos = pos + d * w;
        end
        return pos;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: compare last cycle's expectation, then drive new inputs.
    task automatic cyc(input bit v, input bit st, input int idx);
        @(negedge clk);
        if (p_valid) begin
            chk(out_valid === 1'b1, "R11 out_valid", int'(out_valid), 1);
            chk(int'(out_pos) == p_pos, {tag, " out_pos"}, int'(out_pos), p_pos);
            chk(out_start === p_start, "R2 out_start", int'(out_start), int'(p_start));
            chk(out_last === p_last, "R7 out_last", int'(out_last), int'(p_last));
            chk(int'(out_size_idx) == p_idx, "R4 out_size_idx", int'(out_size_idx), p_idx);
            if (p_k == 0) begin
                foreach (seen[i]) seen[i] = 1'b0;
                distinct = 0;
            end
            chk(!seen[out_pos], "R5 duplicate position", int'(out_pos), -1);
            if (!seen[out_pos]) distinct++;
            seen[out_pos] = 1'b1;
            if (p_last) chk(distinct == bsize(p_idx), "R5 distinct count", distinct, bsize(p_idx));
        end else begin
            chk(out_valid === 1'b0, "R6 out_valid idle", int'(out_valid), 0);
            chk(out_last === 1'b0, "R6 out_last idle", int'(out_last), 0);
        end
        in_valid    = v;
        in_start    = st;
        in_size_idx = 3'(idx);
        p_valid = v;
        if (v) begin
            if (st) begin
                m_idx = idx;
                m_k = 0;
            end else begin
                m_k = (m_k + 1) % bsize(m_idx);
            end
            p_start = st;
            p_k     = m_k;
            p_idx   = m_idx;
            p_pos   = ref_pos(m_idx, m_k);
            p_last  = (m_k == bsize(m_idx) - 1);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        finish_up();
    end

    initial begin
        foreach (seen[i]) seen[i] = 1'b0;
        distinct = 0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_start === 1'b0, "R1 out_start", int'(out_start), 0);
        chk(out_last === 1'b0, "R1 out_last", int'(out_last), 0);
        chk(out_size_idx === 3'd0, "R1 out_size_idx", int'(out_size_idx), 0);
        rst_n = 1'b1;
        m_idx = 0;
        m_k = bsize(0) - 1;
        cyc(0, 0, 0);
        cyc(0, 0, 0);

        // R10 and R9: start-less samples after reset, run past one frame.
        tag = "R10";
        for (int k = 0; k < 30; k++) cyc(1, 0, 5);
        cyc(0, 0, 0);

        // R8 and R3: every size back to back, continuous valid.
        tag = "R8";
        for (int s = 0; s < 8; s++)
            for (int k = 0; k < bsize(s); k++) cyc(1, k == 0, s);

        // R6: gaps with start and size noise on idle and non-start cycles.
        tag = "R6";
        for (int s = 7; s >= 0; s--) begin
            int n = 0;
            int g = s;
            while (n < bsize(s)) begin
                g++;
                if ((g * 7) % 5 == 0) cyc(0, 1, (g + 3) % 8);
                else begin
                    cyc(1, n == 0, (n == 0) ? s : (g % 8));
                    n++;
                end
            end
        end

        // R9: one start, then more than two frames of samples.
        tag = "R9";
        cyc(1, 1, 2);
        for (int k = 1; k < 2 * 36 + 5; k++) cyc(1, 0, 2);

        // R12: restart in mid frame with a new size.
        tag = "R12";
        cyc(1, 1, 4);
        for (int k = 1; k < 17; k++) cyc(1, 0, 4);
        cyc(1, 1, 6);
        for (int k = 1; k < 96; k++) cyc(1, 0, 6);
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        finish_up();
    end

endmodule